// File: doc/BRIEF.md
# Scan-Loaded Region Power-Down Decoder

This block lets a test controller isolate one region of a multi-core chip for quiescent supply-current measurement without a dedicated pin per core. A serial instruction enters a small shift stage, one bit per clock, under capture and shift strobes. An update strobe decodes the shifted code into a set of registered supply-enable lines. There is one line per embedded core and one line for the shared glue region.

A core-select instruction keeps exactly one core supplied and cuts every other region, including the glue region. A glue-only instruction cuts every core and keeps only the glue region supplied. Any other code means normal operation, and every region stays supplied. The decoder is a separate module driven only by the shifted code. The same decode therefore serves a chip-level instruction register or a core-wrapper instruction register.

Top module: `pd_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, every `core_en` bit and `main_en` read 1 and the shift stage holds 0, so `tdo` reads 0. An update right after reset leaves all lines at 1.
- R2: After an update with code 8+i (i = 0, 1, 2 for cores A, B, C), `core_en[i]` is 1 and every other `core_en` bit and `main_en` are 0.
- R3: After an update with code 0xB, every `core_en` bit is 0 and `main_en` is 1.
- R4: After an update with any code outside 0x8 to 0xB (for example 0x0, 0x7, 0xC, 0xF), every `core_en` bit and `main_en` are 1. This also holds after a previous test code.
- R5: `core_en` and `main_en` change only on a clock edge where `update_en` is high. Shifting and capturing leave them unchanged.
- R6: On each edge with `shift_en` high, `tdi` enters the most significant bit and the stage moves right. `tdo` always shows bit 0, so the code leaves least significant bit first.
- R7: On an edge with `capture_en` high, the shift stage loads the pattern 0001 (binary), so the next four bits seen on `tdo` are 1, 0, 0, 0.
- R8: When `capture_en` and `shift_en` are both high, the capture takes precedence.
- R9: Pulling `rst_n` low at any time returns all lines to 1 without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| capture_en | input | 1 | Load the capture pattern into the shift stage |
| shift_en | input | 1 | Shift the stage one bit toward `tdo` |
| update_en | input | 1 | Decode the shift stage into the output lines |
| tdi | input | 1 | Serial instruction input |
| tdo | output | 1 | Serial output, bit 0 of the shift stage |
| core_en | output | NUM_CORES | Per-core supply enable, 0 cuts the core |
| main_en | output | 1 | Glue-region supply enable, 0 cuts the region |

## Verification
`tdo` follows the shift stage with no register of its own. Its new bit is therefore due right after the edge that performed the shift or capture, and the bench reads it at the falling edge that follows. The supply lines sit one register after the decoder, so they are due one edge after `update_en` is sampled high. Each task raises a strobe at a falling edge and lets one rising edge pass. It then reads the outputs at the next falling edge, before any other input moves. For R5, the lines are read at every falling edge of a shift sequence, not only at its end.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } ir_op_e;

endpackage

// File: rtl/pd_ir_shift.sv
module pd_ir_shift
    import pd_pkg::*;
#(
    parameter int unsigned IR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_en,
    input  logic            shift_en,
    input  logic            tdi,
    output logic [IR_W-1:0] shift_q,
    output logic            tdo
);

    localparam logic [IR_W-1:0] CAPTURE_VAL = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0] bits;
    } shift_state_t;

    shift_state_t state_d, state_q;
    ir_op_e       op;

    always_comb begin
        if (capture_en)    op = OP_CAPTURE;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_HOLD;
    end

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CAPTURE: state_d.bits = CAPTURE_VAL;
            OP_SHIFT:   state_d.bits = {tdi, state_q.bits[IR_W-1:1]};
            default:    state_d.bits = state_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign shift_q = state_q.bits;
    assign tdo     = state_q.bits[0];

endmodule

// File: rtl/pd_decode.sv
module pd_decode #(
    parameter int unsigned IR_W      = 4,
    parameter int unsigned NUM_CORES = 3,
    parameter int unsigned CORE_BASE = 8
) (
    input  logic [IR_W-1:0]      code,
    output logic [NUM_CORES-1:0] core_en,
    output logic                 main_en
);

    localparam int unsigned MAIN_CODE = CORE_BASE + NUM_CORES;

    logic [NUM_CORES-1:0] core_hit;
    logic                 main_hit;
    logic                 test_mode;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
        assign core_hit[i] = (code == IR_W'(CORE_BASE + i));
    end

    assign main_hit  = (code == IR_W'(MAIN_CODE));
    assign test_mode = main_hit | (|core_hit);

    always_comb begin
        if (test_mode) begin
            core_en = core_hit;
            main_en = main_hit;
        end else begin
            core_en = '1;
            main_en = 1'b1;
        end
    end

endmodule

// File: rtl/pd_update_reg.sv
module pd_update_reg #(
    parameter int unsigned NUM_CORES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 update_en,
    input  logic [NUM_CORES-1:0] core_en_in,
    input  logic                 main_en_in,
    output logic [NUM_CORES-1:0] core_en_q,
    output logic                 main_en_q
);

    typedef struct packed {
        logic [NUM_CORES-1:0] core;
        logic                 main;
    } en_state_t;

    en_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (update_en) begin
            state_d.core = core_en_in;
            state_d.main = main_en_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.core <= '1;
            state_q.main <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign core_en_q = state_q.core;
    assign main_en_q = state_q.main;

endmodule

// File: rtl/pd_scan_ctrl.sv
module pd_scan_ctrl #(
    parameter int unsigned IR_W      = 4,
    parameter int unsigned NUM_CORES = 3,
    parameter int unsigned CORE_BASE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic                 update_en,
    input  logic                 tdi,
    output logic                 tdo,
    output logic [NUM_CORES-1:0] core_en,
    output logic                 main_en
);

    logic [IR_W-1:0]      ir_shift_q;
    logic [NUM_CORES-1:0] dec_core_en;
    logic                 dec_main_en;

    pd_ir_shift #(
        .IR_W(IR_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .shift_q    (ir_shift_q),
        .tdo        (tdo)
    );

    pd_decode #(
        .IR_W      (IR_W),
        .NUM_CORES (NUM_CORES),
        .CORE_BASE (CORE_BASE)
    ) u_decode (
        .code    (ir_shift_q),
        .core_en (dec_core_en),
        .main_en (dec_main_en)
    );

    pd_update_reg #(
        .NUM_CORES(NUM_CORES)
    ) u_update (
        .clk        (clk),
        .rst_n      (rst_n),
        .update_en  (update_en),
        .core_en_in (dec_core_en),
        .main_en_in (dec_main_en),
        .core_en_q  (core_en),
        .main_en_q  (main_en)
    );

endmodule

// File: rtl/pd_scan_ctrl_chk.sv
module pd_scan_ctrl_chk #(
    parameter int unsigned IR_W      = 4,
    parameter int unsigned NUM_CORES = 3,
    parameter int unsigned CORE_BASE = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 capture_en,
    input logic                 shift_en,
    input logic                 update_en,
    input logic                 tdo,
    input logic [IR_W-1:0]      ir_shift_q,
    input logic [NUM_CORES-1:0] core_en,
    input logic                 main_en
);

    localparam int unsigned MAIN_CODE = CORE_BASE + NUM_CORES;

    logic in_range;
    assign in_range = (ir_shift_q >= IR_W'(CORE_BASE)) && (ir_shift_q <= IR_W'(MAIN_CODE));

    p_reset_release_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> ((&core_en) && main_en));

    p_single_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((&core_en) && main_en) |-> ($countones({core_en, main_en}) == 1));

    p_glue_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && ir_shift_q == IR_W'(MAIN_CODE)) |=> (core_en == '0 && main_en));

    p_normal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && !in_range) |=> ((&core_en) && main_en));

    p_stable_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> ($stable(core_en) && $stable(main_en)));

    p_shift_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (tdo == $past(ir_shift_q[1])));

    p_capture_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (tdo && ir_shift_q[IR_W-1:1] == '0));

endmodule

bind pd_scan_ctrl pd_scan_ctrl_chk #(
    .IR_W      (IR_W),
    .NUM_CORES (NUM_CORES),
    .CORE_BASE (CORE_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .tdo        (tdo),
    .ir_shift_q (ir_shift_q),
    .core_en    (core_en),
    .main_en    (main_en)
);

// File: tb/tb_pd_scan_ctrl.sv
module tb_pd_scan_ctrl;

    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_en = 1'b0;
    logic          shift_en = 1'b0;
    logic          update_en = 1'b0;
    logic          tdi = 1'b0;
    logic          tdo;
    logic [NC-1:0] core_en;
    logic          main_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pd_scan_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .tdi        (tdi),
        .tdo        (tdo),
        .core_en    (core_en),
        .main_en    (main_en)
    );

    function automatic logic [NC:0] expect_lines(input logic [3:0] code);
        if (code >= 4'h8 && code <= 4'hA) return {NC'(1) << (code - 4'h8), 1'b0};
        if (code == 4'hB) return {{NC{1'b0}}, 1'b1};
        return {NC+1{1'b1}};
    endfunction

    task automatic check_lines(input string req, input logic [NC:0] exp);
        checks++;
        if ({core_en, main_en} !== exp) begin
            errors++;
            $display("FAIL %s: core_en/main_en=%b expected %b", req, {core_en, main_en}, exp);
        end
    endtask

    task automatic check_tdo(input string req, input logic exp);
        checks++;
        if (tdo !== exp) begin
            errors++;
            $display("FAIL %s: tdo=%b expected %b", req, tdo, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        shift_en = 1'b1;
        tdi = b;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic shift_code(input logic [3:0] code);
        for (int k = 0; k < 4; k++) shift_bit(code[k]);
    endtask

    task automatic do_update();
        update_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        update_en = 1'b0;
    endtask

    task automatic load_and_check(input string req, input logic [3:0] code);
        shift_code(code);
        do_update();
        check_lines(req, expect_lines(code));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_lines("R1", {NC+1{1'b1}});
        check_tdo("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        do_update();
        check_lines("R1", {NC+1{1'b1}});
    endtask

    task automatic t_cores();
        for (int i = 0; i < NC; i++) load_and_check("R2", 4'(8 + i));
    endtask

    task automatic t_glue();
        load_and_check("R3", 4'hB);
    endtask

    task automatic t_normal();
        load_and_check("R2", 4'h8);
        load_and_check("R4", 4'h0);
        load_and_check("R3", 4'hB);
        load_and_check("R4", 4'h7);
        load_and_check("R4", 4'hC);
        load_and_check("R4", 4'hF);
    endtask

    task automatic t_stable();
        load_and_check("R2", 4'h9);
        for (int k = 0; k < 4; k++) begin
            shift_bit(k == 1 ? 1'b1 : (k == 3));
            check_lines("R5", expect_lines(4'h9));
        end
        capture_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        capture_en = 1'b0;
        check_lines("R5", expect_lines(4'h9));
        load_and_check("R2", 4'hA);
    endtask

    task automatic t_shift_order();
        logic [3:0] pat = 4'b0110;
        shift_code(pat);
        for (int k = 0; k < 4; k++) begin
            check_tdo("R6", pat[k]);
            shift_bit(1'b0);
        end
        check_tdo("R6", 1'b0);
    endtask

    task automatic t_capture();
        capture_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        capture_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_tdo("R7", k == 0);
            shift_bit(1'b1);
        end
    endtask

    task automatic t_precedence();
        shift_code(4'b1110);
        capture_en = 1'b1;
        shift_en = 1'b1;
        tdi = 1'b1;
        @(posedge clk);
        @(negedge clk);
        capture_en = 1'b0;
        shift_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_tdo("R8", k == 0);
            shift_bit(1'b0);
        end
    endtask

    task automatic t_async_reset();
        load_and_check("R2", 4'h8);
        #1 rst_n = 1'b0;
        #0.5;
        check_lines("R9", {NC+1{1'b1}});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_lines("R9", {NC+1{1'b1}});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main_seq
        @(negedge clk);
        t_reset();
        t_cores();
        t_glue();
        t_normal();
        t_stable();
        t_shift_order();
        t_capture();
        t_precedence();
        t_async_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule